// File: doc/BRIEF.md
# Sleep-Aware Pad Control Multiplexer

This block drives the configuration and data of a bank of I/O pads. Every pad owns two configuration words: a run word and a sleep word. When the pad's sleep opt-in flag is set and the chip is in light sleep, the sleep word drives the pad. In all other cases the run word drives it. The configuration covers the function select, drive strength, pull-up, pull-down and output enable. In run mode the output enable comes from the routing-matrix input. Pads on the sleep word take their output enable from a bit inside that word.

A subset of the pads can also reach an always-on low-power domain. These pads are numbered separately. Low-power index i belongs to pad NUM_PADS-1-i. A per-pad routing bit resets to 1, which keeps the pad on the digital path. Clearing the bit hands the pad's output level, output enable and input to the low-power path. On that path the driven level and enable are frozen for the whole of deep sleep. A pad input that matches a per-pad polarity can also raise a level-sensitive wake request. All configuration goes through a flat register write/read port.

Top module: `sleep_pad_mux`

## Requirements
- R1: After reset, every run and sleep word reads 0x00 and every low-power word reads 0x01, which means routing bit set and all other fields 0.
- R2: Address map: addresses 0..NUM_PADS-1 hold the run words, NUM_PADS..2*NUM_PADS-1 hold the sleep words, and 2*NUM_PADS..2*NUM_PADS+NUM_LP-1 hold the low-power words. A write stores the data and the same address reads it back. Run and sleep words keep 8 bits. Low-power words keep bits [4:0].
- R3: Run and sleep words share one layout: func [2:0], drive [4:3], pull-up [5], pull-down [6], flag [7]. In the run word the flag is the sleep opt-in. In the sleep word the flag is the sleep output enable. With sleep_i=1 and the opt-in set, func_o, drv_o, pu_o and pd_o come from the sleep word.
- R4: With the opt-in clear, or with sleep_i=0, those fields come from the run word.
- R5: A pad driven by its run word takes its output enable from mtx_oe_i. A pad driven by its sleep word takes it from bit 7 of the sleep word. On the digital path pad_out_o follows mtx_out_i.
- R6: While a pad's routing bit (low-power word bit 0) is 1, dig_in_o follows pad_in_i and the matching lp_in_o bit is 0.
- R7: While the routing bit is 0, pad_out_o comes from low-power word bit 3 and oe_o from bit 4. In this state dig_in_o is 0 and lp_in_o carries the pad input.
- R8: While deep_i=1, a pad on the low-power path holds the output level and enable it had in the cycle before deep_i rose. Writes made in deep sleep have no effect on the pad until the cycle deep_i falls, and that cycle shows the live values.
- R9: wake_o is high only while deep_i=1 and at least one low-power-routed pad has wake enable (bit 1) set and pad_in equal to its polarity (bit 2).
- R10: Low-power index i maps to pad NUM_PADS-1-i. Pads below NUM_PADS-NUM_LP have no low-power path.
- R11: Writes to addresses at or above 2*NUM_PADS+NUM_LP are ignored, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Light-sleep state, synchronous |
| deep_i | input | 1 | Deep-sleep state, synchronous |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i |
| mtx_oe_i | input | NUM_PADS | Output enables from the routing matrix |
| mtx_out_i | input | NUM_PADS | Output levels from the routing matrix |
| pad_in_i | input | NUM_PADS | Pad input levels |
| func_o | output | 3*NUM_PADS | Function select, 3 bits per pad |
| drv_o | output | 2*NUM_PADS | Drive strength, 2 bits per pad |
| pu_o | output | NUM_PADS | Pull-up enables |
| pd_o | output | NUM_PADS | Pull-down enables |
| oe_o | output | NUM_PADS | Pad output enables |
| pad_out_o | output | NUM_PADS | Pad output levels |
| dig_in_o | output | NUM_PADS | Pad inputs toward the digital path |
| lp_in_o | output | NUM_LP | Pad inputs toward the low-power domain, by low-power index |
| wake_o | output | 1 | Deep-sleep wake request |

## Verification
The hold assertions assume that no routing bit changes while deep_i stays high. For that reason the bench writes low-power words during deep sleep with bit 0 copied from the current routing value. The other assertions assume that sleep_i and deep_i change only between clock edges, like every other input. The bench drives all inputs on the falling edge and sets random values for the matrix and pad-input vectors every cycle. It alternates stretches of random register traffic with deep-sleep episodes. These episodes write new output levels that must stay invisible until deep_i falls.

// File: rtl/spm_pkg.sv
package spm_pkg;
  localparam int PAD_WORD_W = 8;
  localparam int LP_WORD_W  = 5;

  typedef struct packed {
    logic       flag;  // run: sleep opt-in, sleep: output enable
    logic       pd;
    logic       pu;
    logic [1:0] drv;
    logic [2:0] func;
  } pad_word_t;

  typedef struct packed {
    logic oe;
    logic out;
    logic wake_pol;
    logic wake_en;
    logic route_dig;
  } lp_word_t;

  function automatic int lp_to_pad(int lp_idx, int n_pads);
    return n_pads - 1 - lp_idx;
  endfunction
endpackage

// File: rtl/spm_regs.sv
module spm_regs
  import spm_pkg::*;
#(
  parameter int NUM_PADS = 24,
  parameter int NUM_LP   = 18,
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [DATA_W-1:0]       rdata_o,
  output pad_word_t [NUM_PADS-1:0] norm_o,
  output pad_word_t [NUM_PADS-1:0] slp_o,
  output lp_word_t  [NUM_LP-1:0]   lp_o
);
  localparam int SLP_BASE = NUM_PADS;
  localparam int LP_BASE  = 2 * NUM_PADS;
  localparam lp_word_t LP_RST = '{route_dig: 1'b1, default: 1'b0};

  pad_word_t [NUM_PADS-1:0] norm_q, slp_q;
  lp_word_t  [NUM_LP-1:0]   lp_q;

  for (genvar g = 0; g < NUM_PADS; g++) begin : g_pad
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        norm_q[g] <= '0;
        slp_q[g]  <= '0;
      end else if (we_i) begin
        if (addr_i == ADDR_W'(g))            norm_q[g] <= pad_word_t'(wdata_i[PAD_WORD_W-1:0]);
        if (addr_i == ADDR_W'(SLP_BASE + g)) slp_q[g]  <= pad_word_t'(wdata_i[PAD_WORD_W-1:0]);
      end
    end
  end

  for (genvar g = 0; g < NUM_LP; g++) begin : g_lp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lp_q[g] <= LP_RST;
      else if (we_i && addr_i == ADDR_W'(LP_BASE + g))
        lp_q[g] <= lp_word_t'(wdata_i[LP_WORD_W-1:0]);
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_PADS; k++) begin
      if (addr_i == ADDR_W'(k))            rdata_o = DATA_W'(norm_q[k]);
      if (addr_i == ADDR_W'(SLP_BASE + k)) rdata_o = DATA_W'(slp_q[k]);
    end
    for (int k = 0; k < NUM_LP; k++)
      if (addr_i == ADDR_W'(LP_BASE + k)) rdata_o = DATA_W'(lp_q[k]);
  end

  assign norm_o = norm_q;
  assign slp_o  = slp_q;
  assign lp_o   = lp_q;
endmodule

// File: rtl/spm_lp_path.sv
module spm_lp_path
  import spm_pkg::*;
#(
  parameter int NUM_LP = 18
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  deep_i,
  input  lp_word_t [NUM_LP-1:0] lp_i,
  input  logic [NUM_LP-1:0]     pad_in_i,
  output logic [NUM_LP-1:0]     out_o,
  output logic [NUM_LP-1:0]     oe_o,
  output logic [NUM_LP-1:0]     lp_in_o,
  output logic                  wake_o
);
  logic [NUM_LP-1:0] hold_out_q, hold_oe_q, hit;

  for (genvar i = 0; i < NUM_LP; i++) begin : g_ch
    // tracks live value outside deep sleep, frozen inside it
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hold_out_q[i] <= 1'b0;
        hold_oe_q[i]  <= 1'b0;
      end else if (!deep_i) begin
        hold_out_q[i] <= lp_i[i].out;
        hold_oe_q[i]  <= lp_i[i].oe;
      end
    end
    assign out_o[i]   = deep_i ? hold_out_q[i] : lp_i[i].out;
    assign oe_o[i]    = deep_i ? hold_oe_q[i]  : lp_i[i].oe;
    assign lp_in_o[i] = ~lp_i[i].route_dig & pad_in_i[i];
    assign hit[i]     = ~lp_i[i].route_dig & lp_i[i].wake_en
                        & ~(pad_in_i[i] ^ lp_i[i].wake_pol);
  end

  assign wake_o = deep_i & (|hit);
endmodule

// File: rtl/spm_pad_sel.sv
module spm_pad_sel
  import spm_pkg::*;
(
  input  logic       sleep_i,
  input  pad_word_t  norm_i,
  input  pad_word_t  slp_i,
  input  logic       mtx_oe_i,
  input  logic       mtx_out_i,
  input  logic       lp_sel_i,
  input  logic       lp_out_i,
  input  logic       lp_oe_i,
  input  logic       pad_in_i,
  output logic [2:0] func_o,
  output logic [1:0] drv_o,
  output logic       pu_o,
  output logic       pd_o,
  output logic       oe_o,
  output logic       out_o,
  output logic       dig_in_o
);
  logic      use_slp;
  pad_word_t cfg;
  logic      dig_oe;

  assign use_slp  = sleep_i & norm_i.flag;
  assign cfg      = use_slp ? slp_i : norm_i;
  assign dig_oe   = use_slp ? slp_i.flag : mtx_oe_i;

  assign func_o   = cfg.func;
  assign drv_o    = cfg.drv;
  assign pu_o     = cfg.pu;
  assign pd_o     = cfg.pd;
  assign oe_o     = lp_sel_i ? lp_oe_i  : dig_oe;
  assign out_o    = lp_sel_i ? lp_out_i : mtx_out_i;
  assign dig_in_o = ~lp_sel_i & pad_in_i;
endmodule

// File: rtl/sleep_pad_mux.sv
module sleep_pad_mux
  import spm_pkg::*;
#(
  parameter int NUM_PADS = 24,
  parameter int NUM_LP   = 18,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = $clog2(2 * NUM_PADS + NUM_LP)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sleep_i,
  input  logic                  deep_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  input  logic [NUM_PADS-1:0]   mtx_oe_i,
  input  logic [NUM_PADS-1:0]   mtx_out_i,
  input  logic [NUM_PADS-1:0]   pad_in_i,
  output logic [3*NUM_PADS-1:0] func_o,
  output logic [2*NUM_PADS-1:0] drv_o,
  output logic [NUM_PADS-1:0]   pu_o,
  output logic [NUM_PADS-1:0]   pd_o,
  output logic [NUM_PADS-1:0]   oe_o,
  output logic [NUM_PADS-1:0]   pad_out_o,
  output logic [NUM_PADS-1:0]   dig_in_o,
  output logic [NUM_LP-1:0]     lp_in_o,
  output logic                  wake_o
);
  localparam int FIRST_LP = NUM_PADS - NUM_LP;

  pad_word_t [NUM_PADS-1:0] norm_cfg, slp_cfg;
  lp_word_t  [NUM_LP-1:0]   lp_cfg;
  logic [NUM_LP-1:0]        lp_pad_in, lp_drv_out, lp_drv_oe;
  logic [NUM_PADS-1:0]      lp_pad_sel;

  spm_regs #(
    .NUM_PADS(NUM_PADS), .NUM_LP(NUM_LP), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o),
    .norm_o(norm_cfg), .slp_o(slp_cfg), .lp_o(lp_cfg)
  );

  for (genvar i = 0; i < NUM_LP; i++) begin : g_lp_in
    assign lp_pad_in[i] = pad_in_i[lp_to_pad(i, NUM_PADS)];
  end

  spm_lp_path #(.NUM_LP(NUM_LP)) u_lp (
    .clk_i(clk_i), .rst_ni(rst_ni), .deep_i(deep_i), .lp_i(lp_cfg),
    .pad_in_i(lp_pad_in), .out_o(lp_drv_out), .oe_o(lp_drv_oe),
    .lp_in_o(lp_in_o), .wake_o(wake_o)
  );

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    logic sel_lp, lp_out, lp_oe;
    if (p >= FIRST_LP) begin : g_lp
      localparam int LI = NUM_PADS - 1 - p;
      assign sel_lp = ~lp_cfg[LI].route_dig;
      assign lp_out = lp_drv_out[LI];
      assign lp_oe  = lp_drv_oe[LI];
    end else begin : g_dig
      assign sel_lp = 1'b0;
      assign lp_out = 1'b0;
      assign lp_oe  = 1'b0;
    end
    assign lp_pad_sel[p] = sel_lp;

    spm_pad_sel u_sel (
      .sleep_i(sleep_i), .norm_i(norm_cfg[p]), .slp_i(slp_cfg[p]),
      .mtx_oe_i(mtx_oe_i[p]), .mtx_out_i(mtx_out_i[p]),
      .lp_sel_i(sel_lp), .lp_out_i(lp_out), .lp_oe_i(lp_oe),
      .pad_in_i(pad_in_i[p]),
      .func_o(func_o[3*p +: 3]), .drv_o(drv_o[2*p +: 2]),
      .pu_o(pu_o[p]), .pd_o(pd_o[p]), .oe_o(oe_o[p]),
      .out_o(pad_out_o[p]), .dig_in_o(dig_in_o[p])
    );
  end
endmodule

// File: rtl/sleep_pad_mux_chk.sv
module sleep_pad_mux_chk #(
  parameter int NUM_PADS = 24,
  parameter int NUM_LP   = 18,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 7
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                sleep_i,
  input logic                deep_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [DATA_W-1:0]   rdata_o,
  input logic [NUM_PADS-1:0] mtx_oe_i,
  input logic [NUM_PADS-1:0] oe_o,
  input logic [NUM_PADS-1:0] pad_out_o,
  input logic [NUM_PADS-1:0] dig_in_o,
  input logic                wake_o,
  input logic [NUM_PADS-1:0] lp_pad_sel_i
);
  localparam int ADDR_END = 2 * NUM_PADS + NUM_LP;

  a_r9_wake_needs_deep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !deep_i |-> !wake_o);

  a_r8_hold_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deep_i && $past(deep_i) && $stable(lp_pad_sel_i))
      |-> $stable(pad_out_o & lp_pad_sel_i));

  a_r8_hold_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deep_i && $past(deep_i) && $stable(lp_pad_sel_i))
      |-> $stable(oe_o & lp_pad_sel_i));

  a_r7_dig_in_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dig_in_o & lp_pad_sel_i) == '0);

  a_r4_run_oe_from_matrix: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_i |-> ((oe_o ^ mtx_oe_i) & ~lp_pad_sel_i) == '0);

  a_r11_unmapped_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(addr_i) >= ADDR_END) |-> rdata_o == '0);
endmodule

bind sleep_pad_mux sleep_pad_mux_chk #(
  .NUM_PADS(NUM_PADS), .NUM_LP(NUM_LP), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sleep_i(sleep_i), .deep_i(deep_i),
  .addr_i(addr_i), .rdata_o(rdata_o), .mtx_oe_i(mtx_oe_i), .oe_o(oe_o),
  .pad_out_o(pad_out_o), .dig_in_o(dig_in_o), .wake_o(wake_o),
  .lp_pad_sel_i(lp_pad_sel)
);

// File: tb/sim_sleep_pad_mux.sv
`timescale 1ns/1ps
module sim_sleep_pad_mux;
  localparam int NP = 24;
  localparam int NL = 18;
  localparam int DW = 8;
  localparam int AW = 7;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sleep = 1'b0, deep = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic [NP-1:0] mtx_oe = '0, mtx_out = '0, pad_in = '0;
  logic [3*NP-1:0] func;
  logic [2*NP-1:0] drv;
  logic [NP-1:0] pu, pd, oe, pad_out, dig_in;
  logic [NL-1:0] lp_in;
  logic wake;

  int total = 0, bad = 0;
  bit done = 0;

  int  m_norm [NP];
  int  m_slp  [NP];
  int  m_lp   [NL];
  bit  m_hout [NL];
  bit  m_hoe  [NL];

  always #2 clk = ~clk;

  sleep_pad_mux #(.NUM_PADS(NP), .NUM_LP(NL), .DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sleep_i(sleep), .deep_i(deep),
    .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .mtx_oe_i(mtx_oe), .mtx_out_i(mtx_out), .pad_in_i(pad_in),
    .func_o(func), .drv_o(drv), .pu_o(pu), .pd_o(pd), .oe_o(oe),
    .pad_out_o(pad_out), .dig_in_o(dig_in), .lp_in_o(lp_in), .wake_o(wake)
  );

  task automatic cmp(string tag, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    logic [3*NP-1:0] e_func = '0;
    logic [2*NP-1:0] e_drv = '0;
    logic [NP-1:0] e_pu = '0, e_pd = '0, e_oe = '0, e_out = '0, e_din = '0;
    logic [NL-1:0] e_lpin = '0;
    logic e_wake = 1'b0;
    int e_rd;
    for (int p = 0; p < NP; p++) begin
      bit use_s, lpsel;
      int w, li;
      use_s = sleep && ((m_norm[p] >> 7) & 1);
      w = use_s ? m_slp[p] : m_norm[p];
      e_func[3*p +: 3] = 3'(w & 7);
      e_drv[2*p +: 2]  = 2'((w >> 3) & 3);
      e_pu[p] = 1'((w >> 5) & 1);
      e_pd[p] = 1'((w >> 6) & 1);
      li = NP - 1 - p;
      lpsel = (p >= NP - NL) && ((m_lp[li] & 1) == 0);
      if (lpsel) begin
        e_out[p] = deep ? m_hout[li] : 1'((m_lp[li] >> 3) & 1);
        e_oe[p]  = deep ? m_hoe[li]  : 1'((m_lp[li] >> 4) & 1);
        e_lpin[li] = pad_in[p];
        if (deep && ((m_lp[li] >> 1) & 1) && (int'(pad_in[p]) == ((m_lp[li] >> 2) & 1)))
          e_wake = 1'b1;
      end else begin
        e_out[p] = mtx_out[p];
        e_oe[p]  = use_s ? 1'((m_slp[p] >> 7) & 1) : mtx_oe[p];
        e_din[p] = pad_in[p];
      end
    end
    if (int'(addr) < NP) e_rd = m_norm[addr];
    else if (int'(addr) < 2*NP) e_rd = m_slp[int'(addr) - NP];
    else if (int'(addr) < 2*NP + NL) e_rd = m_lp[int'(addr) - 2*NP];
    else e_rd = 0;
    cmp("R3 R4 func", 128'(func), 128'(e_func));
    cmp("R3 R4 drive", 128'(drv), 128'(e_drv));
    cmp("R3 R4 pullup", 128'(pu), 128'(e_pu));
    cmp("R3 R4 pulldown", 128'(pd), 128'(e_pd));
    cmp("R5 R7 R8 oe", 128'(oe), 128'(e_oe));
    cmp("R5 R7 R8 pad_out", 128'(pad_out), 128'(e_out));
    cmp("R6 R7 dig_in", 128'(dig_in), 128'(e_din));
    cmp("R7 R10 lp_in", 128'(lp_in), 128'(e_lpin));
    cmp("R9 wake", 128'(wake), 128'(e_wake));
    cmp("R1 R2 R11 rdata", 128'(rdata), 128'(e_rd));
  endtask

  task automatic model_edge();
    if (!deep)
      for (int i = 0; i < NL; i++) begin
        m_hout[i] = 1'((m_lp[i] >> 3) & 1);
        m_hoe[i]  = 1'((m_lp[i] >> 4) & 1);
      end
    if (we) begin
      int a = int'(addr);
      if (a < NP) m_norm[a] = int'(wdata);
      else if (a < 2*NP) m_slp[a - NP] = int'(wdata);
      else if (a < 2*NP + NL) m_lp[a - 2*NP] = int'(wdata) & 32'h1f;
    end
  endtask

  task automatic cycle(bit w, int a, int d, bit s, bit dp);
    @(negedge clk);
    we = w; addr = AW'(a); wdata = DW'(d); sleep = s; deep = dp;
    mtx_oe = NP'($urandom); mtx_out = NP'($urandom); pad_in = NP'($urandom);
    #1;
    check_outputs();
    model_edge();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < NP; p++) begin m_norm[p] = 0; m_slp[p] = 0; end
    for (int i = 0; i < NL; i++) begin m_lp[i] = 1; m_hout[i] = 0; m_hoe[i] = 0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1: read every register after reset
    for (int a = 0; a < 2*NP + NL; a++) cycle(0, a, 0, 0, 0);
    // R2 R3 R4 R5 R6 R7 R11: random traffic, light sleep toggling
    for (int k = 0; k < 900; k++)
      cycle($urandom_range(0, 3) != 0, $urandom_range(0, 127), $urandom_range(0, 255),
            $urandom_range(0, 1), 0);
    // R8 R9: deep-sleep episodes; route bits kept stable while deep
    for (int e = 0; e < 40; e++) begin
      for (int k = 0; k < 4; k++) begin
        int li = $urandom_range(0, NL - 1);
        cycle(1, 2*NP + li, $urandom_range(0, 31) & ~($urandom_range(0, 2) == 0 ? 0 : 1),
              $urandom_range(0, 1), 0);
      end
      for (int k = 0; k < 8; k++) begin
        int li = $urandom_range(0, NL - 1);
        int d = ($urandom_range(0, 31) & 32'h1e) | (m_lp[li] & 1);
        cycle($urandom_range(0, 1), 2*NP + li, d, $urandom_range(0, 1), 1);
      end
      cycle(0, $urandom_range(0, 127), 0, 0, 0);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule